// File: doc/BRIEF.md
# Sign-Magnitude Capture Counter with Status Flag

This block provides the digital half of a dual-slope conversion system. A 12-bit binary counter, built as a cascade of 4-bit stages, is cleared by a counter-clear pulse and advances on each rising edge of the converter's pulse train. When the counter wraps from all ones to zero, it sends a one-cycle carry pulse back to the converter. The converter uses this pulse both to end input integration and to detect an overrange.

At the falling edge of the active-low end-of-conversion strobe, an output register captures a 14-bit sign-magnitude word. The positive-polarity flag becomes the top bit, the overrange flag sits just below it, and the 12-bit count fills the rest. A busy flag goes high on the falling edge of the active-low convert command and drops on the end-of-conversion strobe. The captured word may be used only while the flag is low.

All inputs are treated as synchronous levels that are sampled on the rising clock edge. Each edge detector compares the current sample with the previous one.

Top module: `signmag_capture`

## Requirements
- R1: While `rst_n` is low at a clock edge, the counter clears to 0, and `word`, `busy` and `carry` all read 0 after that edge.
- R2: Each low-to-high change of `pulse_in` between two consecutive clock samples adds exactly one to the count. Holding `pulse_in` high for many cycles counts once.
- R3: `cnt_clr` high at a clock edge sets the count to 0 after that edge, even if a pulse rise is seen at the same edge.
- R4: A pulse rise while the count is 4095 wraps the count to 0 and raises `carry` for exactly one cycle, beginning after the same edge. At all other times `carry` is 0.
- R5: A high-to-low change of `eoc_n` between consecutive samples loads `word` after that edge as follows: bit 13 = `pol_pos`, bit 12 = `ovr_in`, bits 11:0 = the count held before that edge.
- R6: Outside an `eoc_n` falling edge, `word` keeps its value no matter how `pol_pos`, `ovr_in`, `pulse_in` or `cnt_clr` change.
- R7: A high-to-low change of `conv_n` sets `busy` to 1, and an `eoc_n` fall clears it to 0. When both falls happen at the same edge, `busy` is set.
- R8: With no fall on either `conv_n` or `eoc_n`, `busy` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cnt_clr | input | 1 | Counter clear pulse, active high |
| pulse_in | input | 1 | Converter pulse train; each rising edge counts |
| eoc_n | input | 1 | End-of-conversion strobe, active low; its fall loads the output |
| conv_n | input | 1 | Convert command, active low; its fall sets busy |
| pol_pos | input | 1 | Positive-polarity flag from the converter |
| ovr_in | input | 1 | Overrange flag from the converter |
| word | output | 14 | Captured sign-magnitude result |
| busy | output | 1 | High from convert command to end of conversion |
| carry | output | 1 | One-cycle pulse when the counter wraps to zero |

## Verification
Every result is due exactly one clock edge after the sample that causes it: a count step or clear, the wrap and its carry, a capture into `word`, and a change of `busy`. No result appears in the same cycle as its cause. The bench drives inputs on the falling clock edge and updates a behavioural model on the rising edge. It compares `word`, `busy` and `carry` on the following falling edge, when both the model and the design have taken that one step. Directed checks read the count only through a capture strobe, sampled on the falling edge after the strobe's low sample. For the wrap, the bench checks `carry` in the cycle straight after the 4096th rise and again one cycle later.

// File: rtl/sm_cap_pkg.sv
// Package sm_cap_pkg
// Shared defaults and types for the sign-magnitude capture block.
// Assumes: counter built from equal-width binary stages.
package sm_cap_pkg;
    localparam int DEF_STAGE_W  = 4;
    localparam int DEF_N_STAGES = 3;

    // Which transition an edge detector reports.
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } edge_kind_e;
endpackage

// File: rtl/sm_edge_det.sv
// Module sm_edge_det
// Reports a chosen transition of a synchronous level input by comparing the
// current sample with the one from the previous clock.
// Assumes: sig is already synchronous to clk; after reset the stored sample
// is the line's idle level, so no false edge follows reset.
module sm_edge_det #(
    parameter sm_cap_pkg::edge_kind_e KIND = sm_cap_pkg::EDGE_RISE
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig,
    output logic hit
);
    import sm_cap_pkg::*;

    localparam logic IDLE = (KIND == EDGE_FALL);

    logic prev;

    // Keep the previous sample of the input.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= IDLE;
        else        prev <= sig;
    end

    generate
        if (KIND == EDGE_RISE) begin : g_rise
            assign hit = sig & ~prev;
        end else begin : g_fall
            assign hit = ~sig & prev;
        end
    endgenerate
endmodule

// File: rtl/sm_cnt_stage.sv
// Module sm_cnt_stage
// One binary stage of the cascaded counter; clear wins over enable.
// Assumes: enable already includes the carry-in from lower stages.
module sm_cnt_stage #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] q,
    output logic         full
);
    // Stage register: clear, then step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= '0;
        else if (en)       q <= q + 1'b1;
    end

    assign full = &q;

    p_stage_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q == '0));
endmodule

// File: rtl/sm_bin_counter.sv
// Module sm_bin_counter
// Cascaded binary counter with a registered one-cycle wrap pulse.
// Assumes: inc is a single-cycle event; clr has priority over inc.
module sm_bin_counter #(
    parameter int STAGE_W  = sm_cap_pkg::DEF_STAGE_W,
    parameter int N_STAGES = sm_cap_pkg::DEF_N_STAGES
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        inc,
    output logic [STAGE_W*N_STAGES-1:0] count,
    output logic                        carry
);
    localparam int CNT_W = STAGE_W * N_STAGES;

    logic [N_STAGES:0]   chain;
    logic [N_STAGES-1:0] full;

    assign chain[0] = inc;

    generate
        for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
            sm_cnt_stage #(.W(STAGE_W)) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (clr),
                .en    (chain[i]),
                .q     (count[i*STAGE_W +: STAGE_W]),
                .full  (full[i])
            );
            assign chain[i+1] = chain[i] & full[i];
        end
    endgenerate

    // Wrap pulse, suppressed when a clear lands on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) carry <= 1'b0;
        else        carry <= chain[N_STAGES] & ~clr;
    end

    p_clear_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (count == '0) && !carry);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (count == CNT_W'($past(count) + 1'b1)));
    p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(count));
    p_carry_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        carry |-> (count == '0));
    p_carry_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        carry |=> !carry);
endmodule

// File: rtl/sm_status_flag.sv
// Module sm_status_flag
// Set/reset flag framing a conversion; set wins when both arrive together.
// Assumes: set and clr are single-cycle edge events.
module sm_status_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set && !clr) |=> $stable(flag));
endmodule

// File: rtl/sm_out_reg.sv
// Module sm_out_reg
// Holding register for the captured result.
// Assumes: load is a single-cycle event.
module sm_out_reg #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture on load, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/signmag_capture.sv
// Module signmag_capture
// Counter and output register for a dual-slope converter, producing a
// sign-magnitude word: polarity on top, overrange below it, count beneath.
// Assumes: all inputs synchronous to clk; eoc_n and conv_n are active low.
module signmag_capture #(
    parameter int STAGE_W  = sm_cap_pkg::DEF_STAGE_W,
    parameter int N_STAGES = sm_cap_pkg::DEF_N_STAGES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cnt_clr,
    input  logic                          pulse_in,
    input  logic                          eoc_n,
    input  logic                          conv_n,
    input  logic                          pol_pos,
    input  logic                          ovr_in,
    output logic [STAGE_W*N_STAGES+1:0]   word,
    output logic                          busy,
    output logic                          carry
);
    import sm_cap_pkg::*;

    localparam int CNT_W  = STAGE_W * N_STAGES;
    localparam int WORD_W = CNT_W + 2;

    logic             pulse_rise;
    logic             eoc_fall;
    logic             conv_fall;
    logic [CNT_W-1:0] count;

    sm_edge_det #(.KIND(EDGE_RISE)) u_pulse_edge (
        .clk(clk), .rst_n(rst_n), .sig(pulse_in), .hit(pulse_rise));
    sm_edge_det #(.KIND(EDGE_FALL)) u_eoc_edge (
        .clk(clk), .rst_n(rst_n), .sig(eoc_n), .hit(eoc_fall));
    sm_edge_det #(.KIND(EDGE_FALL)) u_conv_edge (
        .clk(clk), .rst_n(rst_n), .sig(conv_n), .hit(conv_fall));

    sm_bin_counter #(.STAGE_W(STAGE_W), .N_STAGES(N_STAGES)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (pulse_rise),
        .count (count),
        .carry (carry)
    );

    sm_out_reg #(.W(WORD_W)) u_out (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (eoc_fall),
        .d     ({pol_pos, ovr_in, count}),
        .q     (word)
    );

    sm_status_flag u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (conv_fall),
        .clr   (eoc_fall),
        .flag  (busy)
    );

    p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_fall |=> (word == {$past(pol_pos), $past(ovr_in), $past(count)}));
    p_busy_vs_word_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoc_fall && !conv_fall) |=> !busy);
endmodule

// File: tb/signmag_capture_bench.sv
module signmag_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_clr = 1'b0;
    logic        pulse_in = 1'b0;
    logic        eoc_n = 1'b1;
    logic        conv_n = 1'b1;
    logic        pol_pos = 1'b0;
    logic        ovr_in = 1'b0;
    logic [13:0] word;
    logic        busy;
    logic        carry;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit model_live = 0;

    // Behavioural reference state.
    int          m_cnt;
    logic [13:0] m_word;
    bit          m_busy, m_carry;
    bit          m_pp, m_pe, m_pc;

    signmag_capture u_signmag_capture (
        .clk(clk), .rst_n(rst_n), .cnt_clr(cnt_clr), .pulse_in(pulse_in),
        .eoc_n(eoc_n), .conv_n(conv_n), .pol_pos(pol_pos), .ovr_in(ovr_in),
        .word(word), .busy(busy), .carry(carry));

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Reference model step on every rising edge.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_cnt = 0; m_word = '0; m_busy = 0; m_carry = 0;
            m_pp = 0; m_pe = 1; m_pc = 1;
        end else begin
            bit pr, ef, cf;
            pr = pulse_in && !m_pp;
            ef = !eoc_n && m_pe;
            cf = !conv_n && m_pc;
            m_carry = 0;
            if (ef) m_word = {pol_pos, ovr_in, 12'(m_cnt)};
            if (cnt_clr) m_cnt = 0;
            else if (pr) begin
                if (m_cnt == 4095) begin m_cnt = 0; m_carry = 1; end
                else m_cnt = m_cnt + 1;
            end
            if (cf) m_busy = 1;
            else if (ef) m_busy = 0;
            m_pp = pulse_in; m_pe = eoc_n; m_pc = conv_n;
        end
        model_live = 1;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            summary();
        end
    end

    // Cycle-by-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (model_live) begin
            chk("R5/R6 word per cycle", 32'(word), 32'(m_word));
            chk("R7/R8 busy per cycle", 32'(busy), 32'(m_busy));
            chk("R4 carry per cycle", 32'(carry), 32'(m_carry));
        end
    end

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) pulse_in = 1'b1;
            @(negedge clk) pulse_in = 1'b0;
        end
    endtask

    task automatic end_conv();
        @(negedge clk) eoc_n = 1'b0;
        @(negedge clk) eoc_n = 1'b1;
    endtask

    task automatic start_conv();
        @(negedge clk) conv_n = 1'b0;
        @(negedge clk) conv_n = 1'b1;
    endtask

    task automatic clear_cnt();
        @(negedge clk) cnt_clr = 1'b1;
        @(negedge clk) cnt_clr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 word after reset", 32'(word), 32'h0);
        chk("R1 busy after reset", 32'(busy), 32'h0);
        chk("R1 carry after reset", 32'(carry), 32'h0);
        rst_n = 1'b1;

        // Basic conversion: five pulses, positive, in range.
        start_conv();
        chk("R7 busy set by convert", 32'(busy), 32'h1);
        pol_pos = 1'b1; ovr_in = 1'b0;
        pulses(5);
        end_conv();
        chk("R5 word 5 positive", 32'(word), 32'h2005);
        chk("R7 busy cleared by eoc", 32'(busy), 32'h0);

        // A level held high counts once.
        clear_cnt();
        @(negedge clk) pulse_in = 1'b1;
        repeat (4) @(negedge clk);
        pulse_in = 1'b0;
        pol_pos = 1'b0; ovr_in = 1'b1;
        end_conv();
        chk("R2 held level counts once", 32'(word), 32'h1001);

        // Word and busy hold while inputs wander.
        pol_pos = 1'b1; ovr_in = 1'b0;
        pulses(2);
        clear_cnt();
        chk("R6 word holds", 32'(word), 32'h1001);
        chk("R8 busy holds", 32'(busy), 32'h0);

        // Clear beats a simultaneous pulse rise.
        pulses(3);
        @(negedge clk) begin cnt_clr = 1'b1; pulse_in = 1'b1; end
        @(negedge clk) begin cnt_clr = 1'b0; pulse_in = 1'b0; end
        pol_pos = 1'b0; ovr_in = 1'b0;
        end_conv();
        chk("R3 clear wins over rise", 32'(word), 32'h0000);

        // Wrap: 4096 rises give one carry pulse and a zero count.
        clear_cnt();
        start_conv();
        pulses(4095);
        chk("R4 no carry before wrap", 32'(carry), 32'h0);
        @(negedge clk) pulse_in = 1'b1;
        @(negedge clk) begin
            chk("R4 carry on wrap", 32'(carry), 32'h1);
            pulse_in = 1'b0;
        end
        @(negedge clk) chk("R4 carry lasts one cycle", 32'(carry), 32'h0);
        pulses(2);
        pol_pos = 1'b1; ovr_in = 1'b1;
        end_conv();
        chk("R5 word after wrap", 32'(word), 32'h3002);

        // Convert and end strobe falling together: busy is set.
        pulses(1);
        pol_pos = 1'b0; ovr_in = 1'b1;
        @(negedge clk) begin conv_n = 1'b0; eoc_n = 1'b0; end
        @(negedge clk) begin conv_n = 1'b1; eoc_n = 1'b1; end
        chk("R7 convert wins tie", 32'(busy), 32'h1);
        chk("R5 word on tie", 32'(word), 32'h1003);

        repeat (4) @(negedge clk);
        summary();
    end
endmodule